// File: doc/BRIEF.md
# Serial Register-Access Slave with CRC-8 Frame Guard

This block is the serial front end of a register file. A host drives chip select low, clocks in one access frame MSB first, and raises chip select. The frame carries a read/write flag, a 6-bit register address and 16 bits of data. When frame checking is enabled, it also carries an 8-bit CRC that the host appends, which makes the frame 32 bits long. Without checking, the frame is 24 bits. At the rising edge of chip select the block checks the frame length and, if checking is enabled, the CRC remainder. Only a clean write reaches the register file, through a one-cycle write strobe. Only a clean read fetches data from it, over a read-address and read-data pair.

During the next frame the block shifts out a response word. The response echoes the previous command, flags whether that command was rejected, and carries either the fetched register value or the echoed data. It ends with a CRC that the block computes over its own response. Every rejected frame sets a sticky alarm. The alarm is visible at a status address that the block answers itself, and optionally on an active-low alarm pin. A clean read of that status address clears the alarm.

The serial pins are sampled by a fast system clock through synchronizers, so the whole block lives in one clock domain.

Top module: `spicrc_slave`

## Requirements
- R1: With checking enabled, a 32-bit frame whose CRC is correct and whose bit 31 is 0 produces exactly one `wr_stb` pulse. The pulse carries the address from bits 29:24 and the data from bits 23:8.
- R2: Bit 30 of an incoming frame has no meaning beyond its part in the CRC. The field positions are: bit 31 = 1 for read, 0 for write; bits 29:24 address; bits 23:8 data; bits 7:0 CRC.
- R3: The check divides all 32 received bits by x^8+x^2+x+1, with the remainder starting at zero when chip select falls. A nonzero remainder rejects the frame: no write strobe, no read, and no register changes. Any single flipped bit in a frame is detected.
- R4: A frame whose bit count at the rising edge of chip select differs from the expected length (32 with checking, 24 without) is rejected and flagged as an error.
- R5: The frame after any frame shifts out the response word MSB first, with the first bit valid before the first serial clock rise. The layout is: bit 31 = previous read/write flag; bit 30 = 1 if the previous frame was rejected; bits 29:24 = previous address; bits 23:8 = data; bits 7:0 = the CRC (same polynomial, zero start) of response bits 31:8. For writes and rejected frames, the data field echoes the received data.
- R6: After a clean read, the data field of the next response holds the register value at the read address.
- R7: With checking disabled, frames are 24 bits with no CRC, and the response is its bits 31:8 shifted over 24 clocks. A 32-bit frame in this mode is rejected under R4.
- R8: Any rejected frame sets a sticky alarm. A clean read of address `STATUS_ADDR` returns the alarm in data bit 0 (other bits 0), taken before the clear, and then clears it.
- R9: `alm_n` is low exactly while the alarm is set and `alm_en` is 1, one clock after the alarm changes. Otherwise it is high.
- R10: After reset: alarm clear, `alm_n` high, `miso` low, no write strobe, and the first response is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| chk_en | input | 1 | 1 = 32-bit frames with CRC, 0 = 24-bit frames |
| alm_en | input | 1 | Lets the alarm reach `alm_n` |
| sclk | input | 1 | Serial clock, data sampled on its rise |
| cs_n | input | 1 | Active-low frame select |
| mosi | input | 1 | Serial data from host |
| miso | output | 1 | Serial response to host, changes after sclk fall |
| alm_n | output | 1 | Active-low alarm output |
| wr_stb | output | 1 | One-cycle write strobe to the register file |
| wr_addr | output | 6 | Write address |
| wr_data | output | 16 | Write data |
| rd_addr | output | 6 | Read address, valid from the cycle after a clean read frame |
| rd_data | input | 16 | Register value at `rd_addr`, sampled one cycle after it changes |

## Verification
The bench uses the default parameters: `STATUS_ADDR` = 2 and two synchronizer stages. The serial clock runs at one twelfth of the system clock. Because the address is only six bits wide, every register can be written and then read back through the pipelined response. A separate sweep flips each of the 32 frame bits in turn, so every error position, including the read/write flag and the reserved bit, is exercised along with the alarm set and clear cycle. Short, long and mode-mismatched frames, and a pass with the alarm pin disabled, cover the length check and the pin gating.

// File: rtl/spicrc_pkg.sv
package spicrc_pkg;
  localparam int ADDR_W  = 6;
  localparam int DATA_W  = 16;
  localparam int CRC_W   = 8;
  localparam int HDR_W   = 2 + ADDR_W + DATA_W;
  localparam int FRAME_W = HDR_W + CRC_W;
  localparam int CNT_W   = $clog2(FRAME_W + 2);
  localparam logic [CRC_W-1:0] POLY_LOW = 8'h07;

  // one step of MSB-first polynomial division, remainder register r
  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] r,
                                                 input logic b);
    return {r[CRC_W-2:0], b} ^ (r[CRC_W-1] ? POLY_LOW : '0);
  endfunction
endpackage

// File: rtl/spicrc_sync.sv
module spicrc_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk)
        if (rst) st[g] <= INIT;
        else     st[g] <= d;
    end else begin : g_next
      always_ff @(posedge clk)
        if (rst) st[g] <= INIT;
        else     st[g] <= st[g-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/spicrc_frame.sv
module spicrc_frame
  import spicrc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              chk_en,
  input  logic              sclk_s,
  input  logic              cs_n_s,
  input  logic              mosi_s,
  input  logic [FRAME_W-1:0] tx_word,
  output logic              miso,
  output logic              done,
  output logic [CNT_W-1:0]  rx_len,
  output logic [CRC_W-1:0]  rx_rem,
  output logic              f_rw,
  output logic [ADDR_W-1:0] f_addr,
  output logic [DATA_W-1:0] f_data
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic sclk_q, cs_q;
  logic [FRAME_W-1:0] rx, tx;
  logic sclk_rise, sclk_fall, cs_start, cs_end;

  always_ff @(posedge clk)
    if (rst) begin
      sclk_q <= 1'b0;
      cs_q   <= 1'b1;
    end else begin
      sclk_q <= sclk_s;
      cs_q   <= cs_n_s;
    end

  assign sclk_rise = sclk_s & ~sclk_q;
  assign sclk_fall = ~sclk_s & sclk_q;
  assign cs_start  = ~cs_n_s & cs_q;
  assign cs_end    = cs_n_s & ~cs_q;

  always_ff @(posedge clk)
    if (rst) begin
      rx <= '0; tx <= '0; rx_len <= '0; rx_rem <= '0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (cs_start) begin
        rx     <= '0;
        rx_len <= '0;
        rx_rem <= '0;
        tx     <= tx_word;
      end else if (!cs_n_s) begin
        if (sclk_rise) begin
          rx     <= {rx[FRAME_W-2:0], mosi_s};
          rx_rem <= crc_step(rx_rem, mosi_s);
          if (rx_len != CNT_MAX) rx_len <= rx_len + 1'b1;
        end
        if (sclk_fall) tx <= {tx[FRAME_W-2:0], 1'b0};
      end
      if (cs_end) done <= 1'b1;
    end

  assign miso = tx[FRAME_W-1];

  // field extraction: 32-bit frames carry the header above the CRC byte
  always_comb begin
    if (chk_en) begin
      f_rw   = rx[FRAME_W-1];
      f_addr = rx[FRAME_W-3 -: ADDR_W];
      f_data = rx[CRC_W +: DATA_W];
    end else begin
      f_rw   = rx[HDR_W-1];
      f_addr = rx[HDR_W-3 -: ADDR_W];
      f_data = rx[DATA_W-1:0];
    end
  end

  AST_IDLE_LEN_HOLD: assert property (@(posedge clk) disable iff (rst)
    (cs_n_s && cs_q) |=> $stable(rx_len)) else $error("idle length moved"); // R4
  AST_IDLE_MISO_HOLD: assert property (@(posedge clk) disable iff (rst)
    (cs_n_s && cs_q) |=> $stable(miso)) else $error("idle miso moved"); // R5
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done) else $error("done longer than one cycle"); // R4
endmodule

// File: rtl/spicrc_respgen.sv
module spicrc_respgen
  import spicrc_pkg::*;
(
  input  logic              rw,
  input  logic              err,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic [FRAME_W-1:0] word
);
  logic [HDR_W-1:0]   hdr;
  logic [FRAME_W-1:0] dividend;
  logic [CRC_W-1:0]   chain [FRAME_W+1];

  assign hdr      = {rw, err, addr, data};
  assign dividend = {hdr, {CRC_W{1'b0}}};
  assign chain[0] = '0;

  for (genvar g = 0; g < FRAME_W; g++) begin : g_div
    assign chain[g+1] = crc_step(chain[g], dividend[FRAME_W-1-g]);
  end

  assign word = {hdr, chain[FRAME_W]};
endmodule

// File: rtl/spicrc_slave.sv
module spicrc_slave
  import spicrc_pkg::*;
#(
  parameter logic [5:0] STATUS_ADDR = 6'd2,
  parameter int         SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        chk_en,
  input  logic        alm_en,
  input  logic        sclk,
  input  logic        cs_n,
  input  logic        mosi,
  output logic        miso,
  output logic        alm_n,
  output logic        wr_stb,
  output logic [5:0]  wr_addr,
  output logic [15:0] wr_data,
  output logic [5:0]  rd_addr,
  input  logic [15:0] rd_data
);
  localparam logic [CNT_W-1:0] LEN_CHK   = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] LEN_PLAIN = CNT_W'(HDR_W);

  logic sclk_s, cs_n_s, mosi_s;
  logic f_done, f_rw;
  logic [CNT_W-1:0]  f_len;
  logic [CRC_W-1:0]  f_rem;
  logic [ADDR_W-1:0] f_addr;
  logic [DATA_W-1:0] f_data;
  logic [FRAME_W-1:0] resp_word;
  logic bad;

  logic p_rw, p_err, rd_pend, stat_snap, alarm;
  logic [ADDR_W-1:0] p_addr;
  logic [DATA_W-1:0] r_data;

  spicrc_sync #(.W(3), .STAGES(SYNC_STAGES), .INIT(3'b010)) u_sync (
    .clk(clk), .rst(rst), .d({sclk, cs_n, mosi}), .q({sclk_s, cs_n_s, mosi_s}));

  spicrc_frame u_frame (
    .clk(clk), .rst(rst), .chk_en(chk_en),
    .sclk_s(sclk_s), .cs_n_s(cs_n_s), .mosi_s(mosi_s),
    .tx_word(resp_word), .miso(miso), .done(f_done),
    .rx_len(f_len), .rx_rem(f_rem),
    .f_rw(f_rw), .f_addr(f_addr), .f_data(f_data));

  spicrc_respgen u_resp (
    .rw(p_rw), .err(p_err), .addr(p_addr), .data(r_data), .word(resp_word));

  assign bad = (f_len != (chk_en ? LEN_CHK : LEN_PLAIN)) || (chk_en && (f_rem != '0));

  always_ff @(posedge clk)
    if (rst) begin
      p_rw <= 1'b0; p_err <= 1'b0; p_addr <= '0; r_data <= '0;
      wr_stb <= 1'b0; wr_addr <= '0; wr_data <= '0; rd_addr <= '0;
      rd_pend <= 1'b0; stat_snap <= 1'b0; alarm <= 1'b0; alm_n <= 1'b1;
    end else begin
      wr_stb  <= 1'b0;
      rd_pend <= 1'b0;
      alm_n   <= ~(alm_en & alarm);
      if (f_done) begin
        p_rw      <= f_rw;
        p_err     <= bad;
        p_addr    <= f_addr;
        r_data    <= f_data;
        stat_snap <= alarm;
        if (!bad && !f_rw) begin
          wr_stb  <= 1'b1;
          wr_addr <= f_addr;
          wr_data <= f_data;
        end
        if (!bad && f_rw) begin
          rd_pend <= 1'b1;
          rd_addr <= f_addr;
        end
        if (bad) alarm <= 1'b1;
        else if (f_rw && f_addr == STATUS_ADDR) alarm <= 1'b0;
      end
      if (rd_pend)
        r_data <= (p_addr == STATUS_ADDR) ? {{(DATA_W-1){1'b0}}, stat_snap} : rd_data;
    end

  AST_WR_AFTER_FRAME: assert property (@(posedge clk) disable iff (rst)
    wr_stb |-> ($past(f_done) && !p_err && !p_rw)) else $error("stray write"); // R3
  AST_WR_SINGLE: assert property (@(posedge clk) disable iff (rst)
    wr_stb |=> !wr_stb) else $error("write strobe too long"); // R1
  AST_ALM_CLEAR_SRC: assert property (@(posedge clk) disable iff (rst)
    $fell(alarm) |-> ($past(f_done) && p_rw && !p_err && p_addr == STATUS_ADDR))
    else $error("alarm cleared without status read"); // R8
  AST_ALM_RISE_SRC: assert property (@(posedge clk) disable iff (rst)
    $rose(alarm) |-> p_err) else $error("alarm set without error"); // R8
  AST_PIN_GATED: assert property (@(posedge clk) disable iff (rst)
    !alm_n |-> $past(alm_en && alarm)) else $error("alarm pin without cause"); // R9
endmodule

// File: tb/test_spicrc_slave.sv
`timescale 1ns/1ps
module test_spicrc_slave;
  localparam int HP = 6;
  localparam logic [5:0] SADDR = 6'd2;

  logic clk = 0, rst = 1, chk_en = 1, alm_en = 1;
  logic sclk = 0, cs_n = 1, mosi = 0;
  logic miso, alm_n, wr_stb;
  logic [5:0] wr_addr, rd_addr;
  logic [15:0] wr_data, rd_data;

  logic [15:0] mem [64];
  logic [15:0] emem [64];
  int total = 0, bad = 0, wcnt = 0, wexp = 0;
  logic ealarm = 0;
  logic [31:0] exp_next = 0, exp_mask = 32'hFFFF_FFFF;

  always #2 clk = ~clk;

  spicrc_slave i_spicrc_slave (
    .clk(clk), .rst(rst), .chk_en(chk_en), .alm_en(alm_en),
    .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso), .alm_n(alm_n),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data));

  assign rd_data = mem[rd_addr];
  always @(posedge clk)
    if (rst) begin
      for (int i = 0; i < 64; i++) mem[i] <= 16'h0;
      wcnt <= 0;
    end else if (wr_stb) begin
      mem[wr_addr] <= wr_data;
      wcnt <= wcnt + 1;
    end

  function automatic logic [7:0] hcrc(input logic [23:0] h);
    logic [31:0] m;
    m = {h, 8'h00};
    for (int i = 31; i >= 8; i--) if (m[i]) m = m ^ (32'h107 << (i - 8));
    return m[7:0];
  endfunction

  function automatic logic [31:0] mk(input logic rw, input logic [5:0] a, input logic [15:0] d);
    return {rw, 1'b0, a, d, hcrc({rw, 1'b0, a, d})};
  endfunction

  function automatic logic [31:0] er(input logic rw, input logic e, input logic [5:0] a, input logic [15:0] d);
    return {rw, e, a, d, hcrc({rw, e, a, d})};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [31:0] w, input int n, output logic [31:0] got);
    got = '0;
    @(negedge clk) cs_n = 0;
    repeat (8) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      mosi = (i < 32) ? w[31-i] : 1'b0;
      repeat (HP) @(negedge clk);
      if (i < 32) got[31-i] = miso;
      sclk = 1;
      repeat (HP) @(negedge clk);
      sclk = 0;
    end
    repeat (HP) @(negedge clk);
    cs_n = 1; mosi = 0;
    repeat (12) @(negedge clk);
  endtask

  task automatic frame(input string req, input logic [31:0] w, input int n,
                       input logic [31:0] nexp, input logic [31:0] nmask);
    logic [31:0] got, m;
    int cmpn;
    xfer(w, n, got);
    cmpn = chk_en ? 32 : 24;
    if (n < cmpn) cmpn = n;
    m = ~(32'hFFFF_FFFF >> cmpn) & exp_mask;
    chk((got & m) == (exp_next & m), req, got & m, exp_next & m);
    exp_next = nexp;
    exp_mask = nmask;
  endtask

  task automatic status_clear(input string req);
    frame(req, chk_en ? mk(1, SADDR, 0) : {1'b1, 1'b0, SADDR, 16'h0, 8'h00},
          chk_en ? 32 : 24, er(1, 0, SADDR, {15'h0, ealarm}), 32'hFFFF_FFFF);
    ealarm = 0;
    chk(alm_n == 1'b1, "R9 pin released", {31'h0, alm_n}, 32'h1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] w;
    logic [15:0] d;
    for (int i = 0; i < 64; i++) emem[i] = 16'h0;
    repeat (5) @(negedge clk);
    rst = 0;
    repeat (3) @(negedge clk);
    chk(miso == 1'b0, "R10 miso", {31'h0, miso}, 32'h0);
    chk(alm_n == 1'b1, "R10 alm_n", {31'h0, alm_n}, 32'h1);
    chk(wr_stb == 1'b0, "R10 wr_stb", {31'h0, wr_stb}, 32'h0);

    // R1 / R5: write sweep over every address; first response checks R10 zeros
    for (int a = 0; a < 64; a++) begin
      d = 16'(a * 16'h0409) ^ 16'h5A3C;
      frame(a == 0 ? "R10 first response" : "R5 write echo", mk(0, 6'(a), d), 32,
            er(0, 0, 6'(a), d), 32'hFFFF_FFFF);
      emem[a] = d; wexp++;
    end
    chk(wcnt == wexp, "R1 write count", 32'(wcnt), 32'(wexp));

    // R6: read sweep, each response checked during the following frame
    for (int a = 0; a < 64; a++)
      frame("R5 prev response", mk(1, 6'(a), 16'hFFFF), 32,
            er(1, 0, 6'(a), (6'(a) == SADDR) ? {15'h0, ealarm} : emem[a]), 32'hFFFF_FFFF);
    for (int a = 0; a < 64; a++) begin end
    frame("R6 last read data", mk(1, 6'd7, 16'h0), 32, er(1, 0, 6'd7, emem[7]), 32'hFFFF_FFFF);

    // R3 / R2: flip each frame bit once; nothing may be written
    for (int b = 0; b < 32; b++) begin
      w = mk(0, 6'd7, 16'hC3A5) ^ (32'h1 << b);
      frame("R3 flipped bit", w, 32, er(w[31], 1, w[29:24], w[23:8]), 32'hFFFF_FFFF);
      ealarm = 1;
      chk(alm_n == 1'b0, "R9 pin asserted", {31'h0, alm_n}, 32'h0);
      status_clear("R8 status after flip");
    end
    chk(wcnt == wexp, "R3 no write on bad crc", 32'(wcnt), 32'(wexp));
    frame("R8 status read data", mk(1, 6'd7, 16'h0), 32, er(1, 0, 6'd7, emem[7]), 32'hFFFF_FFFF);

    // R2: reserved bit set with a matching CRC is still a clean write
    w = {1'b0, 1'b1, 6'd9, 16'h1234, hcrc({1'b0, 1'b1, 6'd9, 16'h1234})};
    frame("R6 read of addr 7 unchanged", w, 32, er(0, 0, 6'd9, 16'h1234), 32'hFFFF_FFFF);
    emem[9] = 16'h1234; wexp++;
    frame("R2 reserved bit ignored", mk(1, 6'd9, 16'h0), 32, er(1, 0, 6'd9, 16'h1234), 32'hFFFF_FFFF);

    // R4: short and long frames
    frame("R6 read after reserved write", mk(0, 6'd9, 16'hBEEF), 31, 32'h4000_0000, 32'h4000_0000);
    ealarm = 1;
    status_clear("R4 short frame flagged");
    frame("R8 status returned alarm", mk(0, 6'd9, 16'hBEEF), 33, 32'h4000_0000, 32'h4000_0000);
    ealarm = 1;
    status_clear("R4 long frame flagged");
    chk(wcnt == wexp, "R4 no write on bad length", 32'(wcnt), 32'(wexp));

    // R9: alarm pin disabled
    alm_en = 0;
    w = mk(0, 6'd9, 16'h0) ^ 32'h0000_0100;
    frame("R8 status returned alarm", w, 32, er(0, 1, 6'd9, w[23:8]), 32'hFFFF_FFFF);
    ealarm = 1;
    chk(alm_n == 1'b1, "R9 pin gated off", {31'h0, alm_n}, 32'h1);
    frame("R9 error echo", mk(1, SADDR, 0), 32, er(1, 0, SADDR, 16'h1), 32'hFFFF_FFFF);
    ealarm = 0;
    alm_en = 1;

    // R7: checking disabled, 24-bit frames
    chk_en = 0;
    frame("R8 gated status read", {1'b0, 1'b0, 6'd12, 16'h0F0F, 8'h00}, 24,
          er(0, 0, 6'd12, 16'h0F0F), 32'hFFFF_FFFF);
    emem[12] = 16'h0F0F; wexp++;
    frame("R7 plain write echo", {1'b1, 1'b0, 6'd12, 16'h0, 8'h00}, 24,
          er(1, 0, 6'd12, 16'h0F0F), 32'hFFFF_FFFF);
    w = mk(0, 6'd13, 16'h7777);
    frame("R7 plain read data", w, 32, 32'h4000_0000, 32'h4000_0000);
    ealarm = 1;
    chk(alm_n == 1'b0, "R7 full frame rejected in plain mode", {31'h0, alm_n}, 32'h0);
    status_clear("R7 malformed flag");
    frame("R7 status in plain mode", {1'b1, 1'b0, 6'd12, 16'h0, 8'h00}, 24,
          er(1, 0, 6'd12, 16'h0F0F), 32'hFFFF_FFFF);
    chk_en = 1;
    frame("R7 plain read again", mk(1, 6'd13, 16'h0), 32, er(1, 0, 6'd13, emem[13]), 32'hFFFF_FFFF);
    frame("R6 addr 13 untouched", mk(1, 6'd0, 16'h0), 32, 32'h0, 32'h0);
    chk(wcnt == wexp, "R1 final write count", 32'(wcnt), 32'(wexp));

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule